// File: doc/BRIEF.md
# Single-Accumulator Stored-Program Processor

This block is a very small processor. It keeps one working register, the accumulator. Code and data share one on-chip word array of 64 locations. Each instruction runs in two clock cycles. In the first cycle the word at the program counter is copied into an instruction register. In the second cycle that word is decoded and executed. An instruction word carries three fields: an operation code, a flag that selects the operand kind, and a six-bit operand. When the flag is clear, the operand is a memory address and the word stored there goes to the arithmetic unit. When the flag is set, the operand itself, zero-extended, goes to the arithmetic unit.

A host fills the array through a small side port while the core is held in reset. It reads results back through the same port once the core has stopped. Host writes are refused while a program is running, so the core alone owns the array during execution. The program counter and the accumulator are brought out for observation.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter and the accumulator become 0 and `halted` becomes 0.
- R2: Instructions alternate between a fetch cycle and an execute cycle. The program counter and the accumulator change only at the edge that ends an execute cycle.
- R3: An instruction word has the operation code in bits [9:7], the operand-kind flag in bit [6] and the operand in bits [5:0]. When the flag is 0, the arithmetic input is the memory word at the operand address. When the flag is 1, it is the operand zero-extended to 10 bits.
- R4: Code 000 (load) puts 0 plus the selected value into the accumulator.
- R5: Code 001 adds the selected value to the accumulator. Code 010 subtracts the selected value from the accumulator. Both results wrap modulo 1024.
- R6: Code 011 (store) writes the accumulator to the memory word at the operand address, whatever the flag is. The accumulator does not change.
- R7: Code 100 loads the operand into the program counter. Code 101 does the same only when the accumulator is zero; otherwise the counter steps by one.
- R8: Every other instruction steps the program counter by one, wrapping from 63 to 0. Code 110 changes nothing else.
- R9: Code 111 raises `halted` at the end of its execute cycle. The program counter stays at the address of that instruction. From then on, the counter, the accumulator and the memory stay fixed until reset, except for host writes.
- R10: A host write (`hst_we`) takes effect only at an edge where `rst` is high or `halted` is high. `hst_rdata` always shows the memory word at `hst_addr`, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hst_we | input | 1 | Host write strobe for the memory |
| hst_addr | input | 6 | Host memory address, used for both write and read |
| hst_wdata | input | 10 | Host write data |
| hst_rdata | output | 10 | Memory word at `hst_addr`, combinational |
| halted | output | 1 | High once a halt instruction has executed |
| dbg_pc | output | 6 | Current program counter |
| dbg_acc | output | 10 | Current accumulator |

## Verification
The assertions check five things on every cycle. A fetch is always followed by an execute, with the counter and accumulator held. A non-jump, non-halt execute advances the counter by exactly one. A halted core holds its state. Reset clears the visible state. The core and the host never write the memory in the same cycle. The arithmetic results, the operand-kind selection, the taken and not-taken conditional jump, the counter wrap at 63, and the refusal of host writes during a run can only be shown by the bench. It runs short programs against a behavioural model and reads memory back through the host port.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'b000,
    OP_ADD   = 3'b001,
    OP_SUB   = 3'b010,
    OP_STORE = 3'b011,
    OP_JUMP  = 3'b100,
    OP_JUMPZ = 3'b101,
    OP_SPARE = 3'b110,
    OP_HALT  = 3'b111
  } opcode_t;

  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_EXEC  = 2'd1,
    PH_HALT  = 2'd2
  } phase_t;

  typedef enum logic {
    ALU_ADD = 1'b0,
    ALU_SUB = 1'b1
  } alu_op_t;

endpackage

// File: rtl/acc_ram.sv
module acc_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  alu_op_t           op,
  input  logic [DATA_W-1:0] left,
  input  logic [DATA_W-1:0] right,
  output logic [DATA_W-1:0] result
);
  // Arithmetic wraps at the word width.
  function automatic logic [DATA_W-1:0] calc(alu_op_t f, logic [DATA_W-1:0] a,
                                             logic [DATA_W-1:0] b);
    if (f == ALU_SUB) return a - b;
    return a + b;
  endfunction

  assign result = calc(op, left, right);
endmodule

// File: rtl/acc_decode.sv
module acc_decode
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 10
) (
  input  logic [DATA_W-1:0] ir,
  output logic [ADDR_W-1:0] operand,
  output logic              imm_sel,
  output alu_op_t           alu_op,
  output logic              acc_we,
  output logic              zero_left,
  output logic              do_store,
  output logic              do_jump,
  output logic              do_jumpz,
  output logic              do_halt
);
  localparam int OPC_LSB = DATA_W - 3;
  localparam int IMM_BIT = DATA_W - 4;

  opcode_t opc;

  assign opc     = opcode_t'(ir[DATA_W-1:OPC_LSB]);
  assign imm_sel = ir[IMM_BIT];
  assign operand = ir[ADDR_W-1:0];

  always_comb begin
    alu_op    = ALU_ADD;
    acc_we    = 1'b0;
    zero_left = 1'b0;
    do_store  = 1'b0;
    do_jump   = 1'b0;
    do_jumpz  = 1'b0;
    do_halt   = 1'b0;
    unique case (opc)
      OP_LOAD:  begin acc_we = 1'b1; zero_left = 1'b1; end
      OP_ADD:   acc_we = 1'b1;
      OP_SUB:   begin acc_we = 1'b1; alu_op = ALU_SUB; end
      OP_STORE: do_store = 1'b1;
      OP_JUMP:  do_jump = 1'b1;
      OP_JUMPZ: do_jumpz = 1'b1;
      OP_HALT:  do_halt = 1'b1;
      default:  ;
    endcase
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hst_we,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [DATA_W-1:0] hst_wdata,
  output logic [DATA_W-1:0] hst_rdata,
  output logic              halted,
  output logic [ADDR_W-1:0] dbg_pc,
  output logic [DATA_W-1:0] dbg_acc
);
  localparam int PAD_W = DATA_W - ADDR_W;

  phase_t            phase;
  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] ir;

  logic [ADDR_W-1:0] d_operand;
  logic              d_imm, d_acc_we, d_zero_left, d_store, d_jump, d_jumpz, d_halt;
  alu_op_t           d_alu_op;

  logic [ADDR_W-1:0] core_raddr;
  logic [DATA_W-1:0] core_rdata;
  logic [DATA_W-1:0] sel_value;
  logic [DATA_W-1:0] alu_left;
  logic [DATA_W-1:0] alu_out;

  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;

  // Named events, observed by the bound checker.
  logic in_fetch, in_exec, ex_jump, ex_halt, core_we, host_we_eff;

  assign in_fetch    = (phase == PH_FETCH);
  assign in_exec     = (phase == PH_EXEC);
  assign halted      = (phase == PH_HALT);
  assign ex_jump     = in_exec && (d_jump || (d_jumpz && (acc == '0)));
  assign ex_halt     = in_exec && d_halt;
  assign core_we     = in_exec && d_store && !rst;
  assign host_we_eff = hst_we && (rst || halted);

  acc_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .ir        (ir),
    .operand   (d_operand),
    .imm_sel   (d_imm),
    .alu_op    (d_alu_op),
    .acc_we    (d_acc_we),
    .zero_left (d_zero_left),
    .do_store  (d_store),
    .do_jump   (d_jump),
    .do_jumpz  (d_jumpz),
    .do_halt   (d_halt)
  );

  // Core read port: the counter while fetching, the operand while executing.
  assign core_raddr = in_fetch ? pc : d_operand;

  // Operand multiplexer: memory word or the immediate field.
  assign sel_value = d_imm ? {{PAD_W{1'b0}}, d_operand} : core_rdata;
  assign alu_left  = d_zero_left ? '0 : acc;

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .op     (d_alu_op),
    .left   (alu_left),
    .right  (sel_value),
    .result (alu_out)
  );

  assign mem_we    = core_we || host_we_eff;
  assign mem_waddr = core_we ? d_operand : hst_addr;
  assign mem_wdata = core_we ? acc : hst_wdata;

  acc_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .raddr_a (core_raddr),
    .rdata_a (core_rdata),
    .raddr_b (hst_addr),
    .rdata_b (hst_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_FETCH;
      pc    <= '0;
      acc   <= '0;
      ir    <= '0;
    end else begin
      unique case (phase)
        PH_FETCH: begin
          ir    <= core_rdata;
          phase <= PH_EXEC;
        end
        PH_EXEC: begin
          if (d_acc_we) acc <= alu_out;
          if (d_halt) begin
            phase <= PH_HALT;
          end else begin
            phase <= PH_FETCH;
            pc    <= ex_jump ? d_operand : pc + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign dbg_pc  = pc;
  assign dbg_acc = acc;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              in_fetch,
  input logic              in_exec,
  input logic              halted,
  input logic              ex_jump,
  input logic              ex_halt,
  input logic              core_we,
  input logic              host_we_eff,
  input logic [ADDR_W-1:0] pc,
  input logic [DATA_W-1:0] acc
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (pc == '0 && acc == '0 && !halted)); // R1
  AST_FETCH_THEN_EXEC: assert property (@(posedge clk) disable iff (rst) in_fetch |=> (in_exec && $stable(pc) && $stable(acc))); // R2
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst) (in_exec && !ex_jump && !ex_halt) |=> (pc == ADDR_W'($past(pc) + 1'b1))); // R8
  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (rst) halted |=> (halted && $stable(pc) && $stable(acc))); // R9
  AST_SINGLE_WRITER: assert property (@(posedge clk) disable iff (rst) $onehot0({core_we, host_we_eff})); // R10
endmodule

bind acc_cpu acc_cpu_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_fetch    (in_fetch),
  .in_exec     (in_exec),
  .halted      (halted),
  .ex_jump     (ex_jump),
  .ex_halt     (ex_halt),
  .core_we     (core_we),
  .host_we_eff (host_we_eff),
  .pc          (pc),
  .acc         (acc)
);

// File: tb/acc_cpu_test.sv
module acc_cpu_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 10;
  localparam int NWORDS = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hst_we = 1'b0;
  logic [AW-1:0] hst_addr = '0;
  logic [DW-1:0] hst_wdata = '0;
  logic [DW-1:0] hst_rdata;
  logic          halted;
  logic [AW-1:0] dbg_pc;
  logic [DW-1:0] dbg_acc;

  int checks = 0;
  int errors = 0;

  // Behavioural reference state.
  int m_mem [NWORDS];
  int m_pc, m_acc, m_ir;
  int m_ph;  // 0 fetch, 1 execute, 2 stopped
  int prog [NWORDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk       (clk),
    .rst       (rst),
    .hst_we    (hst_we),
    .hst_addr  (hst_addr),
    .hst_wdata (hst_wdata),
    .hst_rdata (hst_rdata),
    .halted    (halted),
    .dbg_pc    (dbg_pc),
    .dbg_acc   (dbg_acc)
  );

  function automatic int enc(int op, int imm, int opd);
    return op * 128 + imm * 64 + opd;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    int opc, imm, opd, val;
    bit hw;
    hw = hst_we && (rst || m_ph == 2);
    if (rst) begin
      m_pc = 0; m_acc = 0; m_ph = 0;
      if (hw) m_mem[hst_addr] = hst_wdata;
    end else if (m_ph == 0) begin
      m_ir = m_mem[m_pc];
      m_ph = 1;
    end else if (m_ph == 1) begin
      opc = m_ir / 128;
      imm = (m_ir / 64) % 2;
      opd = m_ir % 64;
      val = imm ? opd : m_mem[opd];
      case (opc)
        0: m_acc = val;
        1: m_acc = (m_acc + val) % 1024;
        2: m_acc = (m_acc - val + 1024) % 1024;
        3: m_mem[opd] = m_acc;
        default: ;
      endcase
      if (opc == 7) m_ph = 2;
      else begin
        m_ph = 0;
        if (opc == 4 || (opc == 5 && m_acc == 0)) m_pc = opd;
        else m_pc = (m_pc + 1) % 64;
      end
    end else begin
      if (hw) m_mem[hst_addr] = hst_wdata;
    end
  endtask

  // One clock: model follows the edge, outputs compared in the low phase.
  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(dbg_pc == m_pc, "R2", "per-cycle pc", dbg_pc, m_pc);
    check(dbg_acc == m_acc, "R2", "per-cycle acc", dbg_acc, m_acc);
    check(halted == (m_ph == 2), "R2", "per-cycle halted", halted, m_ph == 2);
  endtask

  task automatic load_program();
    rst = 1'b1;
    for (int i = 0; i < NWORDS; i++) begin
      hst_we = 1'b1; hst_addr = AW'(i); hst_wdata = DW'(prog[i]);
      tick();
    end
    hst_we = 1'b0;
    tick();
    rst = 1'b0;
  endtask

  task automatic run_to_halt();
    for (int n = 0; n < 400 && !halted; n++) tick();
  endtask

  task automatic peek(input int addr, input int exp, input string req);
    hst_addr = AW'(addr);
    #1;
    check(hst_rdata == DW'(exp), req, $sformatf("mem[%0d]", addr), hst_rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NWORDS; i++) m_mem[i] = 0;
    m_pc = 0; m_acc = 0; m_ph = 0; m_ir = 0;

    // Program 1: memory-operand load, add, store, halt.
    for (int i = 0; i < NWORDS; i++) prog[i] = 0;
    prog[0] = enc(0, 0, 13);
    prog[1] = enc(1, 0, 14);
    prog[2] = enc(3, 0, 15);
    prog[3] = enc(7, 0, 0);
    prog[13] = 100;
    prog[14] = 250;
    load_program();
    check(dbg_pc == 0 && dbg_acc == 0, "R1", "pc/acc after reset", dbg_acc, 0);
    check(halted == 1'b0, "R1", "halted after reset", halted, 0);
    // R10: host writes during the run must be refused.
    hst_we = 1'b1; hst_addr = 6'd20; hst_wdata = 10'd341;
    tick(); tick(); tick();
    hst_we = 1'b0;
    run_to_halt();
    check(halted == 1'b1, "R9", "halt raised", halted, 1);
    check(dbg_acc == 350, "R4", "load then add", dbg_acc, 350);
    check(dbg_pc == 3, "R9", "pc held at halt address", dbg_pc, 3);
    peek(15, 350, "R6");
    peek(20, 0, "R10");
    for (int n = 0; n < 10; n++) tick();
    check(dbg_pc == 3 && dbg_acc == 350, "R9", "frozen after halt", dbg_acc, 350);
    hst_we = 1'b1; hst_addr = 6'd40; hst_wdata = 10'd77;
    tick();
    hst_we = 1'b0;
    peek(40, 77, "R10");

    // Program 2: immediates, wrap, conditional jumps, spare code, store with flag.
    for (int i = 0; i < NWORDS; i++) prog[i] = 0;
    prog[0]  = enc(0, 1, 5);
    prog[1]  = enc(2, 1, 7);
    prog[2]  = enc(1, 0, 30);
    prog[3]  = enc(5, 0, 9);
    prog[4]  = enc(2, 1, 1);
    prog[5]  = enc(5, 0, 9);
    prog[6]  = enc(7, 0, 0);
    prog[9]  = enc(6, 1, 21);
    prog[10] = enc(1, 1, 63);
    prog[11] = enc(3, 1, 31);
    prog[12] = enc(4, 0, 20);
    prog[13] = enc(7, 0, 0);
    prog[20] = enc(7, 0, 0);
    prog[30] = 3;
    load_program();
    tick(); tick(); tick(); tick();
    check(dbg_acc == 1022, "R5", "sub wraps below zero", dbg_acc, 1022);
    run_to_halt();
    check(dbg_pc == 20, "R7", "jumps end at 20", dbg_pc, 20);
    check(dbg_acc == 63, "R3", "immediate operand used", dbg_acc, 63);
    peek(31, 63, "R6");
    peek(30, 3, "R8");

    // Program 3: counter wraps from 63 to 0.
    for (int i = 0; i < NWORDS; i++) prog[i] = 0;
    prog[0]  = enc(5, 0, 62);
    prog[1]  = enc(7, 0, 0);
    prog[62] = enc(0, 1, 1);
    prog[63] = enc(1, 1, 2);
    load_program();
    run_to_halt();
    check(dbg_pc == 1, "R8", "pc wrapped then halted", dbg_pc, 1);
    check(dbg_acc == 3, "R7", "jumpz not taken on nonzero", dbg_acc, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule